// File: doc/BRIEF.md
# Marked-Start Serial Command Receiver

This block sits in every slave on a shared, low-rate, master-to-slave serial command line. Each 8-bit command word travels in an asynchronous frame: one low start bit, eight data bits least significant first, and one high stop bit. Bit timing comes from a tick that runs at 16 times the bit rate, and each bit is sampled in the middle. The top data bit of every word is a message marker. A set marker means that the word opens a new message, and its low seven bits then hold the target address. A clear marker means that the word continues the current message, and its low seven bits carry payload.

Any marked word resynchronises the receiver, whatever state it was in. The receiver takes a message when the address in the marked word equals its own node address or equals the all-ones broadcast value. It then hands each later payload word to the local command logic, one single-cycle strobe per word, with a flag on the first payload word. Messages for other nodes are skipped until the next marked word arrives. A message ends when the next marked word arrives: at that point a single-cycle done strobe reports that a taken message has closed. A frame whose stop bit samples low is discarded and cancels the message in progress.

Top module: `marked_cmd_rx`

## Requirements
- R1: After reset all outputs are 0 and the receiver skips unmarked words: it delivers no payload until a marked word with a matching address has been received.
- R2: The receiver decodes frames made of a low start bit, eight data bits sent least significant bit first, and a high stop bit. Each bit lasts 16 ticks of CLK_DIV clocks. Data bit 7 is the marker, and bits 6:0 appear unchanged on pay_data.
- R3: A marked word whose bits 6:0 equal node_addr opens a message. Each later unmarked word raises pay_valid for exactly one cycle, with pay_data set to that word's bits 6:0.
- R4: A marked word whose address matches neither node_addr nor 7'h7F makes the receiver drop all following unmarked words, with no pay_valid.
- R5: Address 7'h7F is a broadcast that every node accepts, whatever its node_addr.
- R6: pay_first is high together with pay_valid on the first payload word of a taken message and low on every later one.
- R7: msg_done pulses for one cycle when a marked word arrives while a message is being taken. It does not pulse when the receiver was skipping.
- R8: A frame whose stop bit samples low is dropped and ends the current message without a msg_done pulse. Unmarked words after it are ignored until the next marked word.
- R9: A marked word always restarts address matching, even in the middle of a taken message.
- R10: A word begins only on a high-to-low transition of the line that is still low at the middle of the start bit. A shorter low pulse is ignored.
- R11: pay_valid and msg_done are never high in the same cycle, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Serial command line, idles high, asynchronous to clk |
| node_addr | input | 7 | Address of this node, held static |
| pay_valid | output | 1 | One-cycle strobe for a delivered payload word |
| pay_data | output | 7 | Payload bits of the delivered word |
| pay_first | output | 1 | Delivered word is the first payload of its message |
| msg_done | output | 1 | One-cycle strobe: a taken message has been closed by a new marked word |

## Verification
The assertions assume that the line changes no faster than the frame format allows, so that at most one decoded word leaves the deserialiser per frame time and node_addr stays fixed while a message is in flight. The stimulus drives whole frames, each bit exactly 16 ticks long with a high gap between frames, and it changes node_addr only while reset is asserted. The short low pulse and the low stop bit are the only deliberate departures from the format, and each is followed by an idle high period before the next frame starts.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

  typedef enum logic {
    MSG_SKIP = 1'b0,
    MSG_TAKE = 1'b1
  } msg_state_t;
endpackage

// File: rtl/cmdrx_tick.sv
module cmdrx_tick #(
  parameter int CLK_DIV = 203
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);

  generate
    if (CLK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_count
      logic [DIV_W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt  <= '0;
          tick <= 1'b0;
        end else if (cnt == DIV_W'(CLK_DIV - 1)) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt  <= cnt + 1'b1;
          tick <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cmdrx_deser.sv
module cmdrx_deser
  import cmdrx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx_in,
  output logic              word_ok,
  output logic              word_err,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(WORD_W);

  logic             rx_m, rx_s, rx_d;
  rx_state_t        st;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitn;

  // two-flop synchroniser plus one delay stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      rx_d <= 1'b1;
    end else begin
      rx_m <= rx_in;
      rx_s <= rx_m;
      rx_d <= rx_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      word     <= '0;
      word_ok  <= 1'b0;
      word_err <= 1'b0;
    end else begin
      word_ok  <= 1'b0;
      word_err <= 1'b0;
      unique case (st)
        RX_IDLE: begin
          if (rx_d && !rx_s) begin
            st  <= RX_START;
            cnt <= '0;
          end
        end
        RX_START: if (tick) begin
          if (cnt == CNT_W'(OVS/2 - 1)) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (cnt == CNT_W'(OVS - 1)) begin
            cnt  <= '0;
            word <= {rx_s, word[WORD_W-1:1]};
            if (bitn == BIT_W'(WORD_W - 1)) st <= RX_STOP;
            else bitn <= bitn + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (cnt == CNT_W'(OVS - 1)) begin
            cnt      <= '0;
            word_ok  <= rx_s;
            word_err <= !rx_s;
            st       <= RX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  assert_stop_good_R2: assert property (@(posedge clk) disable iff (rst)
    word_ok |-> $past(rx_s));
  assert_stop_bad_R8: assert property (@(posedge clk) disable iff (rst)
    word_err |-> !$past(rx_s));
  assert_one_result_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({word_ok, word_err}));
  assert_start_edge_R10: assert property (@(posedge clk) disable iff (rst)
    (st == RX_IDLE && $past(st) == RX_IDLE && !(rx_d && !rx_s)) |=> st == RX_IDLE);
endmodule

// File: rtl/cmdrx_msg.sv
module cmdrx_msg
  import cmdrx_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int ADDR_W = WORD_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_ok,
  input  logic              word_err,
  input  logic [WORD_W-1:0] word,
  input  logic [ADDR_W-1:0] node_addr,
  output logic              pay_valid,
  output logic [ADDR_W-1:0] pay_data,
  output logic              pay_first,
  output logic              msg_done
);
  localparam logic [ADDR_W-1:0] BCAST = {ADDR_W{1'b1}};

  msg_state_t        ms;
  logic              first_pend;
  logic              mark;
  logic [ADDR_W-1:0] body;
  logic              hit;

  assign mark = word[WORD_W-1];
  assign body = word[ADDR_W-1:0];
  assign hit  = (body == node_addr) || (body == BCAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ms         <= MSG_SKIP;
      first_pend <= 1'b0;
      pay_valid  <= 1'b0;
      pay_data   <= '0;
      pay_first  <= 1'b0;
      msg_done   <= 1'b0;
    end else begin
      pay_valid <= 1'b0;
      pay_first <= 1'b0;
      msg_done  <= 1'b0;
      if (word_err) begin
        ms         <= MSG_SKIP;
        first_pend <= 1'b0;
      end else if (word_ok) begin
        if (mark) begin
          msg_done   <= (ms == MSG_TAKE);
          ms         <= hit ? MSG_TAKE : MSG_SKIP;
          first_pend <= hit;
        end else if (ms == MSG_TAKE) begin
          pay_valid  <= 1'b1;
          pay_data   <= body;
          pay_first  <= first_pend;
          first_pend <= 1'b0;
        end
      end
    end
  end

  assert_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(pay_valid && msg_done));
  assert_pay_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    pay_valid |=> !pay_valid);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    msg_done |=> !msg_done);
  assert_first_R6: assert property (@(posedge clk) disable iff (rst)
    pay_first |-> pay_valid);
  assert_pay_src_R3: assert property (@(posedge clk) disable iff (rst)
    pay_valid |-> ($past(word_ok) && !$past(mark)));
  assert_done_src_R7: assert property (@(posedge clk) disable iff (rst)
    msg_done |-> ($past(word_ok) && $past(mark)));
  assert_err_abort_R8: assert property (@(posedge clk) disable iff (rst)
    word_err |=> !pay_valid && !msg_done);
endmodule

// File: rtl/marked_cmd_rx.sv
module marked_cmd_rx #(
  parameter int CLK_DIV = 203,
  parameter int OVS     = 16,
  parameter int WORD_W  = 8,
  localparam int ADDR_W = WORD_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_in,
  input  logic [ADDR_W-1:0] node_addr,
  output logic              pay_valid,
  output logic [ADDR_W-1:0] pay_data,
  output logic              pay_first,
  output logic              msg_done
);
  logic              tick;
  logic              word_ok, word_err;
  logic [WORD_W-1:0] word;

  cmdrx_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  cmdrx_deser #(.OVS(OVS), .WORD_W(WORD_W)) u_deser (
    .clk(clk), .rst(rst), .tick(tick), .rx_in(rx_in),
    .word_ok(word_ok), .word_err(word_err), .word(word)
  );

  cmdrx_msg #(.WORD_W(WORD_W)) u_msg (
    .clk(clk), .rst(rst), .word_ok(word_ok), .word_err(word_err),
    .word(word), .node_addr(node_addr),
    .pay_valid(pay_valid), .pay_data(pay_data),
    .pay_first(pay_first), .msg_done(msg_done)
  );
endmodule

// File: tb/sim_marked_cmd_rx.sv
module sim_marked_cmd_rx;
  localparam int CLK_DIV = 2;
  localparam int OVS     = 16;
  localparam int BITCLK  = CLK_DIV * OVS;
  localparam logic [6:0] NODE = 7'h15;

  // entry: word[11:4], stop_ok[3], exp_pay[2], exp_first[1], exp_done[0]
  localparam int NV = 14;
  localparam logic [11:0] VEC [NV] = '{
    {8'h22, 1'b1, 1'b0, 1'b0, 1'b0},  // R1 payload straight after reset ignored
    {8'h95, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 own address opens message
    {8'h11, 1'b1, 1'b1, 1'b1, 1'b0},  // R3 R6 first payload
    {8'h5A, 1'b1, 1'b1, 1'b0, 1'b0},  // R6 later payload not first
    {8'hA0, 1'b1, 1'b0, 1'b0, 1'b1},  // R7 R4 other node, closes ours
    {8'h33, 1'b1, 1'b0, 1'b0, 1'b0},  // R4 skipped
    {8'hFF, 1'b1, 1'b0, 1'b0, 1'b0},  // R7 no done while skipping, R5 broadcast
    {8'h01, 1'b1, 1'b1, 1'b1, 1'b0},  // R5 broadcast payload delivered
    {8'h44, 1'b0, 1'b0, 1'b0, 1'b0},  // R8 bad stop dropped
    {8'h02, 1'b1, 1'b0, 1'b0, 1'b0},  // R8 message aborted
    {8'h95, 1'b1, 1'b0, 1'b0, 1'b0},  // R8 no done after abort
    {8'h7E, 1'b1, 1'b1, 1'b1, 1'b0},  // R2 bit pattern
    {8'h95, 1'b1, 1'b0, 1'b0, 1'b1},  // R9 restart mid message
    {8'h00, 1'b1, 1'b1, 1'b1, 1'b0}   // R9 first again after restart
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_in = 1'b1;
  logic [6:0] node_addr = NODE;
  logic pay_valid, pay_first, msg_done;
  logic [6:0] pay_data;

  int checks = 0;
  int errors = 0;
  int n_pay = 0;
  int n_done = 0;
  logic [6:0] last_data = '0;
  logic last_first = 1'b0;

  always #4 clk = ~clk;

  marked_cmd_rx #(.CLK_DIV(CLK_DIV), .OVS(OVS), .WORD_W(8)) u0 (
    .clk(clk), .rst(rst), .rx_in(rx_in), .node_addr(node_addr),
    .pay_valid(pay_valid), .pay_data(pay_data),
    .pay_first(pay_first), .msg_done(msg_done)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (pay_valid) begin
        n_pay++;
        last_data  = pay_data;
        last_first = pay_first;
      end
      if (msg_done) n_done++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [7:0] w, input logic stop_ok);
    @(negedge clk) rx_in = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_in = w[i];
      repeat (BITCLK) @(negedge clk);
    end
    rx_in = stop_ok;
    repeat (BITCLK) @(negedge clk);
    rx_in = 1'b1;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic run_word(input logic [7:0] w, input logic stop_ok,
                          input logic e_pay, input logic e_first,
                          input logic e_done, input string req);
    int p0, d0;
    p0 = n_pay;
    d0 = n_done;
    send_word(w, stop_ok);
    chk((n_pay - p0) == int'(e_pay), {req, " payload count"}, n_pay - p0, int'(e_pay));
    chk((n_done - d0) == int'(e_done), {req, " done count"}, n_done - d0, int'(e_done));
    if (e_pay) begin
      chk(last_data == w[6:0], {req, " payload data"}, last_data, w[6:0]);
      chk(last_first == e_first, {req, " first flag"}, last_first, e_first);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state of outputs
    chk({pay_valid, pay_first, msg_done} == 3'b000, "R1 outputs in reset",
        {pay_valid, pay_first, msg_done}, 0);
    rst = 1'b0;
    repeat (BITCLK) @(negedge clk);
    chk({pay_valid, pay_first, msg_done, pay_data} == 10'd0, "R1 outputs after reset",
        {pay_valid, pay_first, msg_done, pay_data}, 0);

    for (int v = 0; v < NV; v++) begin
      run_word(VEC[v][11:4], VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0],
               $sformatf("vector %0d", v));
    end

    // R10: short low pulse on idle line must not start a word
    @(negedge clk) rx_in = 1'b0;
    repeat (BITCLK / 4) @(negedge clk);
    rx_in = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
    run_word(8'h05, 1'b1, 1'b1, 1'b0, 1'b0, "R10 glitch ignored");

    // R1: reset mid message returns to skipping
    @(negedge clk) rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    run_word(8'h06, 1'b1, 1'b0, 1'b0, 1'b0, "R1 skip after reset");

    // R5 broadcast with a different node address (changed during reset)
    @(negedge clk) rst = 1'b1;
    node_addr = 7'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    run_word(8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, "R5 broadcast open");
    run_word(8'h2B, 1'b1, 1'b1, 1'b1, 1'b0, "R5 broadcast payload");
    run_word(8'h95, 1'b1, 1'b0, 1'b0, 1'b1, "R4 old address no longer matches");
    run_word(8'h2C, 1'b1, 1'b0, 1'b0, 1'b0, "R4 skipped after mismatch");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule